// File: doc/BRIEF.md
# Early-Prompt-Late Tracking Correlator Channel

This block is the arithmetic core of one tracking channel for a binary phase-shift keyed spreading-code signal. Each cycle flagged by `sample_vld` it takes a 2-bit intermediate-frequency sample and multiplies it by quantized cosine and sine replicas of the local carrier, which gives an in-phase and a quadrature product. Each product then feeds three accumulators, one each for the early, prompt and late copies of the replica code. The replica code bit of an arm chooses whether that arm adds or subtracts the product, so the block has no separate code multiplier.

The carrier replica comes from an internal phase accumulator that advances by `nco_step` on every accepted sample. The code replica enters one bit at a time on `code_bit` and moves along a short delay line each time `chip_en` is high. A controlling loop sets `nco_step`, supplies the code chips, and pulses `dump` at the end of each coherent integration period, which is normally a whole number of code periods. On each dump the six sums move to output registers and `sums_vld` is high for one cycle.

Top module: `epl_correlator`

## Requirements
- R1: While `rst_n` is low, all six outputs are zero, `sums_vld` is low, the carrier phase is zero, the code delay line is all zeros, and every accumulator is zero.
- R2: A sample uses bit 1 as its sign (1 means negative) and bit 0 as its magnitude (0 means 1, 1 means 3). The four sample values are therefore +1, +3, -1 and -3.
- R3: The carrier table index is bits 31:29 of the 32-bit phase. For index k = 0..7 the cosine levels are +2,+1,-1,-2,-2,-1,+1,+2 and the sine levels are +1,+2,+2,+1,-1,-2,-2,-1. The phase begins at zero and grows by `nco_step`, modulo 2^32, on each cycle that has `sample_vld` high. A sample is mixed with the phase held before its own increment.
- R4: The in-phase product is sample times cosine level and the quadrature product is sample times sine level. Each product takes one of the values ±1, ±2, ±3 or ±6.
- R5: An arm adds the product when its code bit is 1 and subtracts it when its code bit is 0. The code bits used are the ones held in the delay line before that cycle's shift.
- R6: When `chip_en` is high, `code_bit` enters the delay line. Early is the newest bit, prompt is the bit before it, and late is the oldest. When `chip_en` is low the delay line holds.
- R7: When `dump` is high, the sums collected before this cycle go to the outputs and `sums_vld` is high in the next cycle only. Each accumulator then starts again from this cycle's contribution, or from zero if `sample_vld` is low.
- R8: When `sample_vld` is low, neither the accumulators nor the carrier phase change.
- R9: The accumulators are `ACC_W` bits wide (16 by default), two's complement, and wrap modulo 2^ACC_W.
- R10: The six outputs hold their values between dumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_vld | input | 1 | The current sample is accepted |
| if_sample | input | 2 | Sign-magnitude IF sample |
| nco_step | input | 32 | Carrier phase increment per sample |
| code_bit | input | 1 | Next replica code chip |
| chip_en | input | 1 | Shift the code delay line |
| dump | input | 1 | End of the integration period |
| sum_ie | output | ACC_W | In-phase early sum |
| sum_ip | output | ACC_W | In-phase prompt sum |
| sum_il | output | ACC_W | In-phase late sum |
| sum_qe | output | ACC_W | Quadrature early sum |
| sum_qp | output | ACC_W | Quadrature prompt sum |
| sum_ql | output | ACC_W | Quadrature late sum |
| sums_vld | output | 1 | One-cycle pulse: new sums are present |

## Verification
A wrong carrier phase or a wrong table entry only appears at the next dump. It then shows as in-phase and quadrature sums that do not match a sample-by-sample recomputation. A delay line that is misordered or shifts at the wrong time makes the early, prompt and late sums trade places, and this also shows one dump later. An accumulator that skips a restart, or keeps a sample that should have been left out, changes that dump's value and every later one. A wrong pulse shows on `sums_vld` one cycle after the cycle of `dump` that caused it.

// File: rtl/epl_pkg.sv
package epl_pkg;
  localparam int NUM_ARMS = 3;
  localparam int PROD_W   = 4;

  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [2:0]        lvl_t;

  function automatic lvl_t sm_to_level(input logic [1:0] sm);
    lvl_t mag;
    mag = sm[0] ? 3'sd3 : 3'sd1;
    return sm[1] ? -mag : mag;
  endfunction

  function automatic lvl_t cos_level(input logic [2:0] k);
    case (k)
      3'd0, 3'd7: return 3'sd2;
      3'd1, 3'd6: return 3'sd1;
      3'd2, 3'd5: return -3'sd1;
      default:    return -3'sd2;
    endcase
  endfunction

  function automatic lvl_t sin_level(input logic [2:0] k);
    case (k)
      3'd0, 3'd3: return 3'sd1;
      3'd1, 3'd2: return 3'sd2;
      3'd4, 3'd7: return -3'sd1;
      default:    return -3'sd2;
    endcase
  endfunction

  function automatic prod_t mix(input lvl_t a, input lvl_t b);
    logic signed [5:0] p;
    p = 6'(a) * 6'(b);
    return p[PROD_W-1:0];
  endfunction
endpackage

// File: rtl/epl_nco.sv
module epl_nco #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [PHASE_W-1:0] step,
  output logic [IDX_W-1:0]   idx
);
  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (adv) phase <= phase + step;
  end

  assign idx = phase[PHASE_W-1 -: IDX_W];

  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(phase));
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> phase == $past(phase) + $past(step));
endmodule

// File: rtl/epl_code_taps.sv
module epl_code_taps #(
  parameter int ARMS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chip_en,
  input  logic            code_in,
  output logic [ARMS-1:0] taps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       taps <= '0;
    else if (chip_en) taps <= {taps[ARMS-2:0], code_in};
  end

  assert_tap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> $stable(taps));
  assert_tap_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chip_en |=> taps[0] == $past(code_in));
endmodule

// File: rtl/epl_accum.sv
module epl_accum
  import epl_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    add_en,
  input  logic                    add_sel,
  input  prod_t                   prod,
  input  logic                    dump,
  output logic signed [ACC_W-1:0] sum_q
);
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] prod_ext;
  logic signed [ACC_W-1:0] contrib;

  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign contrib  = add_sel ? prod_ext : -prod_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      sum_q <= '0;
    end else if (dump) begin
      sum_q <= acc;
      acc   <= add_en ? contrib : '0;
    end else if (add_en) begin
      acc <= acc + contrib;
    end
  end

  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_en && !dump) |=> $stable(acc));
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dump |=> $stable(sum_q));
  assert_dump_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> sum_q == $past(acc));
endmodule

// File: rtl/epl_correlator.sv
module epl_correlator
  import epl_pkg::*;
#(
  parameter int ACC_W   = 16,
  parameter int PHASE_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_vld,
  input  logic [1:0]              if_sample,
  input  logic [PHASE_W-1:0]      nco_step,
  input  logic                    code_bit,
  input  logic                    chip_en,
  input  logic                    dump,
  output logic signed [ACC_W-1:0] sum_ie,
  output logic signed [ACC_W-1:0] sum_ip,
  output logic signed [ACC_W-1:0] sum_il,
  output logic signed [ACC_W-1:0] sum_qe,
  output logic signed [ACC_W-1:0] sum_qp,
  output logic signed [ACC_W-1:0] sum_ql,
  output logic                    sums_vld
);
  localparam int IDX_W = 3;

  logic [IDX_W-1:0]    car_idx;
  logic [NUM_ARMS-1:0] taps;
  lvl_t                s_lvl;
  prod_t               i_prod;
  prod_t               q_prod;
  logic signed [ACC_W-1:0] sums [2][NUM_ARMS];

  epl_nco #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) u_nco (
    .clk(clk), .rst_n(rst_n), .adv(sample_vld), .step(nco_step), .idx(car_idx)
  );

  epl_code_taps #(.ARMS(NUM_ARMS)) u_taps (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .code_in(code_bit), .taps(taps)
  );

  assign s_lvl  = sm_to_level(if_sample);
  assign i_prod = mix(s_lvl, cos_level(car_idx));
  assign q_prod = mix(s_lvl, sin_level(car_idx));

  for (genvar a = 0; a < NUM_ARMS; a++) begin : g_arm
    for (genvar c = 0; c < 2; c++) begin : g_ch
      epl_accum #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .add_en(sample_vld), .add_sel(taps[a]),
        .prod((c == 0) ? i_prod : q_prod), .dump(dump), .sum_q(sums[c][a])
      );
    end
  end

  assign sum_ie = sums[0][0];
  assign sum_ip = sums[0][1];
  assign sum_il = sums[0][2];
  assign sum_qe = sums[1][0];
  assign sum_qp = sums[1][1];
  assign sum_ql = sums[1][2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sums_vld <= 1'b0;
    else        sums_vld <= dump;
  end

  always_comb begin
    if (rst_n) begin
      assert_prod_levels_R4: assert (i_prod inside {4'sd1, 4'sd2, 4'sd3, 4'sd6,
        -4'sd1, -4'sd2, -4'sd3, -4'sd6} && q_prod inside {4'sd1, 4'sd2, 4'sd3,
        4'sd6, -4'sd1, -4'sd2, -4'sd3, -4'sd6});
    end
  end

  assert_vld_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> sums_vld);
  assert_vld_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dump |=> !sums_vld);
endmodule

// File: tb/tb_epl_correlator.sv
module tb_epl_correlator;
  localparam int ACC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_vld = 1'b0;
  logic [1:0] if_sample = '0;
  logic [31:0] nco_step = '0;
  logic code_bit = 1'b0;
  logic chip_en = 1'b0;
  logic dump = 1'b0;
  logic signed [ACC_W-1:0] sum_ie, sum_ip, sum_il, sum_qe, sum_qp, sum_ql;
  logic sums_vld;

  always #2.5 clk = ~clk;

  epl_correlator #(.ACC_W(ACC_W)) dut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .if_sample(if_sample),
    .nco_step(nco_step), .code_bit(code_bit), .chip_en(chip_en), .dump(dump),
    .sum_ie(sum_ie), .sum_ip(sum_ip), .sum_il(sum_il), .sum_qe(sum_qe),
    .sum_qp(sum_qp), .sum_ql(sum_ql), .sums_vld(sums_vld)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_phase;
  logic [2:0]  m_taps;
  logic signed [ACC_W-1:0] m_acc [6];
  logic signed [ACC_W-1:0] m_out [6];
  logic m_vld;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int samp_val(logic [1:0] s);
    int mag = s[0] ? 3 : 1;
    return s[1] ? -mag : mag;
  endfunction

  function automatic int cos_lv(int k);
    int mag = (k == 0 || k == 3 || k == 4 || k == 7) ? 2 : 1;
    return (k >= 2 && k <= 5) ? -mag : mag;
  endfunction

  function automatic int sin_lv(int k);
    int mag = (k == 1 || k == 2 || k == 5 || k == 6) ? 2 : 1;
    return (k >= 4) ? -mag : mag;
  endfunction

  task automatic model_reset();
    m_phase = '0;
    m_taps  = '0;
    m_vld   = 1'b0;
    for (int i = 0; i < 6; i++) begin
      m_acc[i] = '0;
      m_out[i] = '0;
    end
  endtask

  task automatic compare(input string tag);
    logic signed [ACC_W-1:0] got [6];
    got[0] = sum_ie; got[1] = sum_ip; got[2] = sum_il;
    got[3] = sum_qe; got[4] = sum_qp; got[5] = sum_ql;
    n_tests++;
    if (sums_vld !== m_vld) begin
      n_fail++;
      $display("FAIL %s: sums_vld actual %0b expected %0b", tag, sums_vld, m_vld);
    end
    for (int i = 0; i < 6; i++) begin
      if (got[i] !== m_out[i]) begin
        n_fail++;
        $display("FAIL %s: sum[%0d] actual %0d expected %0d", tag, i, got[i], m_out[i]);
      end
    end
  endtask

  // Inputs are driven after a falling edge; outputs are compared at the next falling edge
  task automatic do_cycle(input logic v, input logic [1:0] s, input logic c,
                          input logic ce, input logic d, input string tag);
    int k, sv, ip, qp, cb;
    logic signed [ACC_W-1:0] contrib [6];
    sample_vld = v; if_sample = s; code_bit = c; chip_en = ce; dump = d;
    k  = int'(m_phase[31:29]);
    sv = samp_val(s);
    ip = sv * cos_lv(k);
    qp = sv * sin_lv(k);
    for (int a = 0; a < 3; a++) begin
      cb = m_taps[a] ? 1 : -1;
      contrib[a]     = ACC_W'(cb * ip);
      contrib[a + 3] = ACC_W'(cb * qp);
    end
    for (int i = 0; i < 6; i++) begin
      if (d) begin
        m_out[i] = m_acc[i];
        m_acc[i] = v ? contrib[i] : '0;
      end else if (v) begin
        m_acc[i] = m_acc[i] + contrib[i];
      end
    end
    m_vld = d;
    if (v)  m_phase = m_phase + nco_step;
    if (ce) m_taps = {m_taps[1:0], c};
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] steps [5];
    steps[0] = 32'h2000_0000; steps[1] = 32'h1000_0000; steps[2] = 32'hE000_0000;
    steps[3] = 32'h1234_5678; steps[4] = 32'h0000_0000;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7: every sample value against every carrier index, random chips
    for (int st = 0; st < 5; st++) begin
      nco_step = steps[st];
      for (int n = 0; n < 48; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        do_cycle(1'b1, 2'(n % 4), lfsr[0], (n % 2) == 0 || lfsr[3],
                 (n % 7) == 6, "R2 R3 R4 R5 R6 R7 sweep");
      end
    end

    // R8: samples withheld on some cycles, chips and dumps keep going
    nco_step = 32'h2000_0000;
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_cycle((n % 3) != 1, 2'(lfsr[2:1]), lfsr[0], lfsr[4], (n % 9) == 8, "R8 gaps");
    end
    // R7: dump on a cycle with no sample restarts from zero; back-to-back dumps
    do_cycle(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, "R7 dump idle");
    do_cycle(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, "R7 dump empty");
    do_cycle(1'b1, 2'b11, 1'b0, 1'b1, 1'b1, "R7 dump with sample");
    do_cycle(1'b1, 2'b10, 1'b1, 1'b1, 1'b1, "R7 dump restart");
    // R10: long stretch without dump, outputs hold
    for (int n = 0; n < 20; n++) do_cycle(1'b1, 2'(n % 4), 1'b1, 1'b1, 1'b0, "R10 hold");

    // R1 again then R9: wraparound with a constant +6 in-phase product
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    compare("R1 second reset");
    rst_n = 1'b1;
    nco_step = '0;
    for (int n = 0; n < 3; n++) do_cycle(1'b0, 2'b01, 1'b1, 1'b1, 1'b0, "R6 fill");
    do_cycle(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, "R9 clear");
    for (int n = 0; n < 6000; n++) begin
      sample_vld = 1'b1; if_sample = 2'b01; code_bit = 1'b1; chip_en = 1'b0; dump = 1'b0;
      for (int i = 0; i < 6; i++) m_acc[i] = m_acc[i] + ACC_W'((i < 3) ? 6 : 3);
      m_vld = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    do_cycle(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, "R9 wrap dump");
    n_tests++;
    if (sum_ip !== -16'sd29536) begin
      n_fail++;
      $display("FAIL R9: wrapped prompt actual %0d expected %0d", sum_ip, -29536);
    end
    n_tests++;
    if (sum_qp !== 16'sd18000) begin
      n_fail++;
      $display("FAIL R9: quadrature prompt actual %0d expected %0d", sum_qp, 18000);
    end
    do_cycle(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, "R7 pulse ends");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule